// File: doc/BRIEF.md
# Radio Common Header Inserter

This block sits in the transmit path of a fronthaul packet mapper. It takes section payloads as a 64-bit packet stream in network byte order and puts a 4-byte time-reference header in front of each packet. The header fields come from sideband inputs. Their values are taken on the start-of-packet beat, and later changes within the packet do not reach the output.

Because the header is half a bus word wide, every payload byte moves four lanes down. The first output beat carries the header in its upper half and the first four payload bytes in its lower half. Each later beat joins the lower half of the previous input beat to the upper half of the current one. If the last input beat leaves fewer than four bytes free, the bytes that spill over need one extra output beat. While that beat is produced the aligner holds its input ready low.

Output beats pass through a FIFO, and a parameter sets its downstream ready latency. With latency 0, a beat transfers on valid and ready together. With latency 3, a beat is presented only in a cycle for which ready was high three cycles earlier, and the sink must accept it.

Top module: `chdr_inserter`

## Requirements
- R1: On a start-of-packet output beat, bits 63:32 hold the header, with the fields packed most significant first: direction flag in bit 63, payload version in 62:60, filter index in 59:56, frame number in 55:48, subframe in 47:44, slot in 43:38 and symbol in 37:32.
- R2: The start-of-packet output beat carries payload bytes 0..3 (input bits 63:32) in bits 31:0. Each later output beat is the lower half of the previous accepted input beat followed by the upper half of the current one, so the output byte stream is the header followed by the payload.
- R3: An input end-of-packet beat whose empty count is 4 or more ends the output packet on the same output beat, with an empty count 4 lower.
- R4: An input end-of-packet beat whose empty count is below 4 produces one extra output end beat. That beat carries the remaining four bytes in bits 63:32 and zeros in bits 31:0, and its empty count is 4 higher. in_ready is low in the cycle after that input beat is accepted.
- R5: The header uses the sideband values present on the accepted start-of-packet beat. Changes to them later in the packet do not alter the output.
- R6: out_error is set only on an output end-of-packet beat, and there it equals in_error of the input end-of-packet beat. in_error on other beats is ignored. out_sop and out_eop each appear exactly once per packet.
- R7: An input beat without start-of-packet that arrives between packets is accepted and discarded, and it produces no output.
- R8: With RDY_LAT=0, a beat shown with out_ready low stays unchanged on the outputs until it is taken. No beat is lost, duplicated or reordered.
- R9: With RDY_LAT=3, out_valid is high only in cycles for which out_ready was high three cycles earlier. No beat is lost or reordered.
- R10: When the FIFO is full, in_ready is low and no beat is written.
- R11: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_data | input | 64 | Payload beat, byte 0 in bits 63:56 |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_empty | input | 3 | Unused bytes on the last beat |
| in_error | input | 1 | Packet error flag, meaningful on the last beat |
| hdr_dir | input | 1 | Data direction field |
| hdr_ver | input | 3 | Payload version field |
| hdr_filter | input | 4 | Filter index field |
| hdr_frame | input | 8 | Frame number field |
| hdr_subframe | input | 4 | Subframe field |
| hdr_slot | input | 6 | Slot field |
| hdr_symbol | input | 6 | Symbol field |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream ready, used with the configured latency |
| out_data | output | 64 | Output beat |
| out_sop | output | 1 | First output beat of a packet |
| out_eop | output | 1 | Last output beat of a packet |
| out_empty | output | 3 | Unused bytes on the last output beat |
| out_error | output | 1 | Packet error flag on the last output beat |

## Verification
A wrong aligner state shows up on the first output beat built after it. A lost or stale held half gives wrong bytes in the lower or upper half of the next beat, and a wrong end decision gives a missing or extra end beat with the wrong empty count, about two cycles after the input beat is accepted. A wrong FIFO pointer or count shows up as duplicated, skipped or reordered beats against the reference byte stream. It can also show up as a missing stall once the buffer fills. In latency-3 mode, a wrong ready history shows up as a beat presented in a cycle that had no permission three cycles earlier.

// File: rtl/chi_pkg.sv
package chi_pkg;
  localparam int BUS_W      = 64;
  localparam int HALF_W     = BUS_W / 2;
  localparam int HALF_BYTES = HALF_W / 8;
  localparam int EMP_W      = $clog2(BUS_W / 8);

  typedef struct packed {
    logic [BUS_W-1:0] data;
    logic             sop;
    logic             eop;
    logic [EMP_W-1:0] empty;
    logic             err;
  } beat_t;

  // field order is the wire order, MSB first
  typedef struct packed {
    logic       dir;
    logic [2:0] ver;
    logic [3:0] filt;
    logic [7:0] frame;
    logic [3:0] subf;
    logic [5:0] slot;
    logic [5:0] sym;
  } hdr_t;

  typedef enum logic [1:0] {ST_HEAD, ST_BODY, ST_TAIL} ast_t;
endpackage

// File: rtl/chi_hdr_pack.sv
module chi_hdr_pack
  import chi_pkg::*;
(
  input  logic       f_dir,
  input  logic [2:0] f_ver,
  input  logic [3:0] f_filt,
  input  logic [7:0] f_frame,
  input  logic [3:0] f_subf,
  input  logic [5:0] f_slot,
  input  logic [5:0] f_sym,
  output hdr_t       hdr
);
  always_comb begin
    hdr.dir   = f_dir;
    hdr.ver   = f_ver;
    hdr.filt  = f_filt;
    hdr.frame = f_frame;
    hdr.subf  = f_subf;
    hdr.slot  = f_slot;
    hdr.sym   = f_sym;
  end
endmodule

// File: rtl/chi_align.sv
module chi_align
  import chi_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BUS_W-1:0] in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [EMP_W-1:0] in_empty,
  input  logic             in_error,
  input  hdr_t             hdr,
  input  logic             space,
  output logic             push,
  output beat_t            push_beat
);
  ast_t              st;
  logic [HALF_W-1:0] held;
  logic [EMP_W-1:0]  held_emp;
  logic              held_err;
  logic              take;
  logic              short_end;

  assign in_ready  = space && (st != ST_TAIL);
  assign take      = in_valid && in_ready;
  assign short_end = in_empty < EMP_W'(HALF_BYTES);

  always_comb begin
    push      = 1'b0;
    push_beat = '0;
    case (st)
      ST_HEAD: if (take && in_sop) begin
        push           = 1'b1;
        push_beat.data = {hdr, in_data[BUS_W-1:HALF_W]};
        push_beat.sop  = 1'b1;
        if (in_eop && !short_end) begin
          push_beat.eop   = 1'b1;
          push_beat.empty = in_empty - EMP_W'(HALF_BYTES);
          push_beat.err   = in_error;
        end
      end
      ST_BODY: if (take) begin
        push           = 1'b1;
        push_beat.data = {held, in_data[BUS_W-1:HALF_W]};
        if (in_eop && !short_end) begin
          push_beat.eop   = 1'b1;
          push_beat.empty = in_empty - EMP_W'(HALF_BYTES);
          push_beat.err   = in_error;
        end
      end
      ST_TAIL: if (space) begin
        push            = 1'b1;
        push_beat.data  = {held, {HALF_W{1'b0}}};
        push_beat.eop   = 1'b1;
        push_beat.empty = held_emp + EMP_W'(HALF_BYTES);
        push_beat.err   = held_err;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_HEAD;
      held     <= '0;
      held_emp <= '0;
      held_err <= 1'b0;
    end else begin
      if (take && (st != ST_HEAD || in_sop)) begin
        held     <= in_data[HALF_W-1:0];
        held_emp <= in_empty;
        held_err <= in_error;
      end
      case (st)
        ST_HEAD: if (take && in_sop)
          st <= in_eop ? (short_end ? ST_TAIL : ST_HEAD) : ST_BODY;
        ST_BODY: if (take && in_eop)
          st <= short_end ? ST_TAIL : ST_HEAD;
        ST_TAIL: if (space) st <= ST_HEAD;
        default: st <= ST_HEAD;
      endcase
    end
  end

  // R4
  tail_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (take && in_eop && short_end && (st != ST_HEAD || in_sop)) |=> !in_ready);

  // R6
  err_on_end_chk: assert property (@(posedge clk) disable iff (rst)
    (push && !push_beat.eop) |-> !push_beat.err);
endmodule

// File: rtl/chi_fifo.sv
module chi_fifo
  import chi_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int RDY_LAT = 0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  push,
  input  beat_t wbeat,
  output logic  full,
  input  logic  out_ready,
  output logic  out_valid,
  output beat_t out_beat
);
  localparam int AW = $clog2(DEPTH);

  beat_t         mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rp;
  logic [AW:0]   cnt;
  logic          pop;

  assign full = (cnt == (AW+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wbeat;
    if (pop)  out_beat <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  generate
    if (RDY_LAT == 0) begin : g_rl0
      assign pop = (cnt != '0) && (!out_valid || out_ready);
      always_ff @(posedge clk) begin
        if (rst)            out_valid <= 1'b0;
        else if (pop)       out_valid <= 1'b1;
        else if (out_ready) out_valid <= 1'b0;
      end

      // R8
      hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_beat)));
    end else begin : g_rln
      localparam int SHW = RDY_LAT - 1;
      logic [SHW-1:0] rsh;
      always_ff @(posedge clk) begin
        if (rst) rsh <= '0;
        else     rsh <= (rsh << 1) | SHW'(out_ready);
      end
      assign pop = (cnt != '0) && rsh[SHW-1];
      always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= pop;
      end

      // R9
      latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(out_ready, RDY_LAT));
    end
  endgenerate

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
endmodule

// File: rtl/chdr_inserter.sv
module chdr_inserter
  import chi_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int RDY_LAT = 0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [63:0] in_data,
  input  logic        in_sop,
  input  logic        in_eop,
  input  logic [2:0]  in_empty,
  input  logic        in_error,
  input  logic        hdr_dir,
  input  logic [2:0]  hdr_ver,
  input  logic [3:0]  hdr_filter,
  input  logic [7:0]  hdr_frame,
  input  logic [3:0]  hdr_subframe,
  input  logic [5:0]  hdr_slot,
  input  logic [5:0]  hdr_symbol,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [63:0] out_data,
  output logic        out_sop,
  output logic        out_eop,
  output logic [2:0]  out_empty,
  output logic        out_error
);
  hdr_t  hdr;
  beat_t wbeat;
  beat_t obeat;
  logic  push;
  logic  full;

  chi_hdr_pack u_pack (
    .f_dir(hdr_dir), .f_ver(hdr_ver), .f_filt(hdr_filter), .f_frame(hdr_frame),
    .f_subf(hdr_subframe), .f_slot(hdr_slot), .f_sym(hdr_symbol), .hdr(hdr)
  );

  chi_align u_align (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty),
    .in_error(in_error), .hdr(hdr), .space(!full), .push(push), .push_beat(wbeat)
  );

  chi_fifo #(.DEPTH(DEPTH), .RDY_LAT(RDY_LAT)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .wbeat(wbeat), .full(full),
    .out_ready(out_ready), .out_valid(out_valid), .out_beat(obeat)
  );

  assign out_data  = obeat.data;
  assign out_sop   = obeat.sop;
  assign out_eop   = obeat.eop;
  assign out_empty = obeat.empty;
  assign out_error = obeat.err;
endmodule

// File: tb/test_chdr_inserter.sv
module test_chdr_inserter;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic [63:0] in_data = '0;
  logic        in_sop = 0, in_eop = 0, in_error = 0;
  logic [2:0]  in_empty = '0;
  logic        f_dir = 0;
  logic [2:0]  f_ver = '0;
  logic [3:0]  f_filt = '0, f_subf = '0;
  logic [7:0]  f_frame = '0;
  logic [5:0]  f_slot = '0, f_sym = '0;
  logic        iv0 = 0, iv1 = 0, rdy0 = 1, rdy1 = 1;
  logic        ir0, ir1, ov0, ov1, os0, os1, oe0, oe1, oer0, oer1;
  logic [63:0] od0, od1;
  logic [2:0]  oem0, oem1;

  int checks = 0, fails = 0;
  int mode0 = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [2:0]  rh = '0;
  logic [69:0] q0 [$];
  logic [69:0] q1 [$];

  chdr_inserter #(.DEPTH(8), .RDY_LAT(0)) i_chdr_inserter (
    .clk(clk), .rst(rst), .in_valid(iv0), .in_ready(ir0), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty), .in_error(in_error),
    .hdr_dir(f_dir), .hdr_ver(f_ver), .hdr_filter(f_filt), .hdr_frame(f_frame),
    .hdr_subframe(f_subf), .hdr_slot(f_slot), .hdr_symbol(f_sym),
    .out_valid(ov0), .out_ready(rdy0), .out_data(od0), .out_sop(os0),
    .out_eop(oe0), .out_empty(oem0), .out_error(oer0));

  chdr_inserter #(.DEPTH(8), .RDY_LAT(3)) i_chdr_inserter_l3 (
    .clk(clk), .rst(rst), .in_valid(iv1), .in_ready(ir1), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty), .in_error(in_error),
    .hdr_dir(f_dir), .hdr_ver(f_ver), .hdr_filter(f_filt), .hdr_frame(f_frame),
    .hdr_subframe(f_subf), .hdr_slot(f_slot), .hdr_symbol(f_sym),
    .out_valid(ov1), .out_ready(rdy1), .out_data(od1), .out_sop(os1),
    .out_eop(oe1), .out_empty(oem1), .out_error(oer1));

  task automatic chk(input bit ok, input string req, input logic [69:0] act, input logic [69:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // downstream ready patterns, changed just after each rising edge
  always @(posedge clk) begin
    rh <= {rh[1:0], rdy1};
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rdy0 = (mode0 == 0) ? 1'b1 : (mode0 == 1) ? lfsr[0] : 1'b0;
    rdy1 = lfsr[3] | lfsr[7];
  end

  // reference comparison every clock
  logic        pv0 = 0, pr0 = 0;
  logic [69:0] pb0 = '0;
  always @(negedge clk) begin
    logic [69:0] a0, a1, e;
    if (!rst) begin
      a0 = {od0, os0, oe0, oem0, oer0};
      a1 = {od1, os1, oe1, oem1, oer1};
      if (pv0 && !pr0) chk(ov0 && a0 == pb0, "R8 hold", a0, pb0);
      if (ov0 && rdy0) begin
        if (q0.size() == 0) chk(0, "R7 spurious beat", a0, '0);
        else begin
          e = q0.pop_front();
          chk(a0 == e, e[5] ? "R1/R2 first beat" : (e[4] ? "R3/R4/R6 end beat" : "R2 body beat"), a0, e);
        end
      end
      if (ov1) begin
        chk(rh[2], "R9 latency", {69'd0, rh[2]}, 70'd1);
        if (q1.size() == 0) chk(0, "R9 spurious beat", a1, '0);
        else begin
          e = q1.pop_front();
          chk(a1 == e, "R9 beat content", a1, e);
        end
      end
      pv0 = ov0; pr0 = rdy0; pb0 = a0;
    end
  end

  task automatic drive_beat(input int sel, input logic [63:0] d, input bit s, input bit e,
                            input logic [2:0] em, input bit er);
    bit acc;
    in_data = d; in_sop = s; in_eop = e; in_empty = em; in_error = er;
    if (sel == 0) iv0 = 1'b1; else iv1 = 1'b1;
    acc = 0;
    while (!acc) begin
      #1;
      acc = (sel == 0) ? ir0 : ir1;
      @(negedge clk);
    end
    iv0 = 1'b0; iv1 = 1'b0;
  endtask

  task automatic send_pkt(input int sel, input int nb, input int seed, input bit err, input bit perturb);
    logic [7:0]  st [72];
    logic [31:0] hv;
    int tot, nout, nin;
    f_dir = seed[0]; f_ver = 3'(seed >> 1); f_filt = 4'(seed >> 2); f_frame = 8'(seed * 3);
    f_subf = 4'(seed >> 3); f_slot = 6'(seed * 5); f_sym = 6'(seed * 7 + 1);
    hv = {f_dir, f_ver, f_filt, f_frame, f_subf, f_slot, f_sym};
    for (int i = 0; i < 72; i++) st[i] = 8'h00;
    for (int i = 0; i < 4; i++) st[i] = hv[31-8*i -: 8];
    for (int i = 0; i < nb; i++) st[4+i] = 8'(seed * 13 + i * 29 + 1);
    tot = nb + 4;
    nout = (tot + 7) / 8;
    for (int k = 0; k < nout; k++) begin
      logic [63:0] d;
      bit lst;
      for (int b = 0; b < 8; b++) d[63-8*b -: 8] = st[k*8+b];
      lst = (k == nout - 1);
      if (sel == 0) q0.push_back({d, k == 0, lst, lst ? 3'(nout*8 - tot) : 3'd0, lst && err});
      else          q1.push_back({d, k == 0, lst, lst ? 3'(nout*8 - tot) : 3'd0, lst && err});
    end
    nin = (nb + 7) / 8;
    for (int j = 0; j < nin; j++) begin
      logic [63:0] d;
      bit lst;
      for (int b = 0; b < 8; b++) d[63-8*b -: 8] = st[4+j*8+b];
      lst = (j == nin - 1);
      // in_error on non-end beats is noise that must be ignored (R6)
      drive_beat(sel, d, j == 0, lst, lst ? 3'(nin*8 - nb) : 3'd0, lst ? err : seed[4]);
      if (perturb && j == 0) begin  // R5: sideband changes after the first beat
        f_dir = ~f_dir; f_frame = ~f_frame; f_sym = ~f_sym; f_ver = ~f_ver;
      end
    end
    if ((nin*8 - nb) < 4)
      chk(!((sel == 0) ? ir0 : ir1), "R4 stall", {69'd0, (sel == 0) ? ir0 : ir1}, '0);
  endtask

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog R8 act=running exp=finished");
    report();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R11
    chk(!ov0 && !ov1, "R11 out_valid", {68'd0, ov0, ov1}, '0);
    chk(ir0 && ir1, "R11 in_ready", {68'd0, ir0, ir1}, 70'd3);

    // free-running sink: R1 R2 R3 R4 R6
    send_pkt(0, 4, 3, 0, 0);
    send_pkt(0, 1, 10, 1, 0);
    send_pkt(0, 5, 21, 0, 0);
    send_pkt(0, 8, 6, 1, 0);
    send_pkt(0, 12, 17, 0, 1);
    send_pkt(0, 13, 40, 1, 1);
    send_pkt(0, 20, 55, 0, 0);
    // R7: stray beat between packets
    drive_beat(0, 64'hDEAD_BEEF_0BAD_F00D, 0, 1, 3'd2, 1);
    send_pkt(0, 3, 77, 1, 0);

    // random sink: R8
    mode0 = 1;
    for (int p = 0; p < 12; p++) send_pkt(0, 1 + (p * 7) % 40, 90 + p, p[0], p[1]);

    // latency-3 instance: R9
    for (int p = 0; p < 12; p++) send_pkt(1, 1 + (p * 11) % 48, 130 + p, p[1], p[0]);

    // full buffer: R10
    mode0 = 2;
    send_pkt(0, 56, 200, 0, 0);
    fork
      send_pkt(0, 16, 201, 1, 0);
      begin
        repeat (20) @(negedge clk);
        chk(!ir0, "R10 full stall", {69'd0, ir0}, '0);
        mode0 = 0;
      end
    join

    mode0 = 0;
    repeat (400) @(negedge clk);
    chk(q0.size() == 0, "R8 beats lost", 70'(q0.size()), '0);
    chk(q1.size() == 0, "R9 beats lost", 70'(q1.size()), '0);
    report();
  end
endmodule